// File: doc/BRIEF.md
# Banked Delay-Line Address Generator

This block turns a 12-bit delay offset from a signal-processing program into a physical address for a 4096-word delay memory. The memory is split into four banks of 1024 words. The two upper offset bits pick the bank. Inside the bank, the word is the bank's ring pointer plus the lower ten offset bits, taken modulo the bank size. A fixed offset therefore names a sample that is a constant number of sampling periods old.

Bank 0 has its own pointer, which moves forward on every sample strobe. Banks 1 to 3 share a second pointer. With the rate select low, this second pointer moves in step with the first. With the rate select high, it moves only on every second strobe. That doubles the delay span of those banks, at the cost of keeping only every other sample. A one-bit phase flip-flop flips on each strobe and decides which strobes the shared pointer takes. The address output is combinational in the offset and the current pointers.

Top module: `dly_bank_addr_gen`

## Requirements
- R1: After reset both pointers and the phase bit are zero, so `addr` equals `offset` for every offset value.
- R2: `addr[11:10]` always equals `offset[11:10]`. A carry out of the in-bank sum never reaches the bank field.
- R3: For `offset[11:10] == 0`, `addr[9:0]` equals `(offset[9:0] + F) mod 1024`, where F is the number of strobes since reset, whatever the rate select is.
- R4: While `rate_sel == 0`, the shared pointer of banks 1 to 3 advances on every strobe. After any run of such strobes started from reset, these banks give the same in-bank address as bank 0 for equal `offset[9:0]`.
- R5: The phase bit starts at 0 and flips on every strobe in either mode. A strobe taken with `rate_sel == 1` advances the shared pointer only when the phase bit is 1 before that strobe. From reset in this mode, the pointer moves on the 2nd, 4th, 6th … strobe.
- R6: Each pointer counts modulo 1024, so 1023 is followed by 0, and the in-bank address wraps in the same way.
- R7: Cycles without `sample_stb` change no pointer. A change of `offset` alone changes `addr` in the same cycle, using the stored pointers.
- R8: A change of `rate_sel` takes effect on the next strobe. The phase bit keeps the value it has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle pulse per sampling period |
| rate_sel | input | 1 | 0: banks 1 to 3 step every sample; 1: every second sample |
| offset | input | 12 | Bank select [11:10] and delay offset in the bank [9:0] |
| addr | output | 12 | Physical delay-memory address |

## Verification
The bench builds the block with its default parameters: a 2-bit bank field and a 10-bit in-bank width. With these values, a bank-0 pointer wrap at 1024 strobes can be reached in a short run, and all four bank codes can be swept. Its model counts strobes per pointer, together with a phase bit. This exposes the half-rate stepping, the phase carried across a mode change, and the absence of a carry into the bank field at offset 3FFh.

// File: rtl/dly_pkg.sv
package dly_pkg;
    typedef enum logic {
        RATE_FULL = 1'b0,
        RATE_HALF = 1'b1
    } dly_rate_e;

    localparam int PTR_FAST = 0;
    localparam int PTR_SLOW = 1;
    localparam int NUM_PTR  = 2;
endpackage

// File: rtl/dly_step_gate.sv
module dly_step_gate
    import dly_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_stb,
    input  logic rate_sel,
    output logic fast_adv,
    output logic slow_adv
);
    typedef struct packed {
        logic phase;
    } gate_st_t;

    gate_st_t st_d, st_q;
    dly_rate_e rate;

    always_comb begin
        rate     = dly_rate_e'(rate_sel);
        st_d     = st_q;
        fast_adv = sample_stb;
        slow_adv = sample_stb && ((rate == RATE_FULL) || st_q.phase);
        if (sample_stb) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: in half-rate mode, two strobes in a row never both advance the slow pointer
    assert_half_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_adv && rate_sel) |=> !(slow_adv && rate_sel));
endmodule

// File: rtl/dly_ring_ptr.sv
module dly_ring_ptr #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

    // R6: the top value is followed by zero
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (ptr == '1)) |=> (ptr == '0));
    // R7: no advance request leaves the pointer unchanged
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
endmodule

// File: rtl/dly_addr_map.sv
module dly_addr_map #(
    parameter int SEL_W  = 2,
    parameter int BANK_W = 10,
    localparam int ADDR_W = SEL_W + BANK_W
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [BANK_W-1:0] fast_ptr,
    input  logic [BANK_W-1:0] slow_ptr,
    output logic [ADDR_W-1:0] addr
);
    logic [SEL_W-1:0]  bank;
    logic [BANK_W-1:0] base;
    logic [BANK_W-1:0] word;

    always_comb begin
        bank = offset[ADDR_W-1:BANK_W];
        base = (bank == '0) ? fast_ptr : slow_ptr;
        word = base + offset[BANK_W-1:0];
        addr = {bank, word};
    end
endmodule

// File: rtl/dly_bank_addr_gen.sv
module dly_bank_addr_gen
    import dly_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int BANK_W = 10,
    localparam int ADDR_W = SEL_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              rate_sel,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] addr
);
    logic [NUM_PTR-1:0] adv;
    logic [BANK_W-1:0]  ptr [NUM_PTR];

    dly_step_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .rate_sel   (rate_sel),
        .fast_adv   (adv[PTR_FAST]),
        .slow_adv   (adv[PTR_SLOW])
    );

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        dly_ring_ptr #(.PTR_W(BANK_W)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[i]),
            .ptr   (ptr[i])
        );
    end

    dly_addr_map #(.SEL_W(SEL_W), .BANK_W(BANK_W)) u_map (
        .offset   (offset),
        .fast_ptr (ptr[PTR_FAST]),
        .slow_ptr (ptr[PTR_SLOW]),
        .addr     (addr)
    );

    // R3: every strobe moves the bank-0 pointer
    assert_fast_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> (ptr[PTR_FAST] != $past(ptr[PTR_FAST])));
    // R4: at full rate, pointers that agree keep agreeing
    assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && !rate_sel && (ptr[PTR_FAST] == ptr[PTR_SLOW]))
        |=> (ptr[PTR_FAST] == ptr[PTR_SLOW]));
    // R2: the bank field follows the offset
    assert_bank_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1:BANK_W] == offset[ADDR_W-1:BANK_W]);
endmodule

// File: tb/sim_dly_bank_addr_gen.sv
module sim_dly_bank_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic        rate_sel = 1'b0;
    logic [11:0] offset = '0;
    logic [11:0] addr;

    int checks = 0;
    int errors = 0;
    logic [9:0] m_fast = '0;
    logic [9:0] m_slow = '0;
    logic       m_phase = 1'b0;

    always #2 clk = ~clk;

    dly_bank_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .rate_sel(rate_sel), .offset(offset), .addr(addr)
    );

    task automatic check(input string tag, input logic [11:0] off);
        logic [11:0] exp;
        offset = off;
        #1;
        exp = {off[11:10], off[9:0] + ((off[11:10] == 2'd0) ? m_fast : m_slow)};
        checks++;
        if (addr !== exp) begin
            errors++;
            $display("FAIL %s offset=%h actual=%h expected=%h", tag, off, addr, exp);
        end
    endtask

    task automatic strobe(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample_stb = 1'b1;
            @(negedge clk);
            sample_stb = 1'b0;
            m_fast++;
            if (!rate_sel || m_phase) m_slow++;
            m_phase = ~m_phase;
        end
    endtask

    task automatic t_reset;
        check("R1", 12'h000);
        check("R1", 12'h5A3);
        check("R1", 12'hFFF);
    endtask

    task automatic t_idle;
        strobe(3);
        repeat (10) @(negedge clk);
        check("R7", 12'h010);
        check("R7", 12'h810);
        check("R7", 12'h000);
    endtask

    task automatic t_full_rate;
        rate_sel = 1'b0;
        strobe(5);
        check("R3", 12'h123);
        check("R4", 12'h523);
        check("R4", 12'hD23);
    endtask

    task automatic t_half_rate;
        rate_sel = 1'b1;
        for (int k = 0; k < 6; k++) begin
            strobe(1);
            check("R5", 12'h404);
            check("R3", 12'h004);
        end
    endtask

    task automatic t_mode_switch;
        rate_sel = 1'b1;
        strobe(1);
        rate_sel = 1'b0;
        strobe(1);
        check("R8", 12'hC00);
        rate_sel = 1'b1;
        strobe(1);
        check("R8", 12'hC00);
        strobe(1);
        check("R8", 12'h800);
    endtask

    task automatic t_bank_edge;
        check("R2", 12'h3FF);
        check("R2", 12'h7FF);
        check("R2", 12'hBFF);
        check("R2", 12'hFFF);
    endtask

    task automatic t_wrap;
        rate_sel = 1'b0;
        strobe(1030);
        check("R6", 12'h000);
        check("R6", 12'h400);
        check("R6", 12'h3FF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_full_rate();
        t_half_rate();
        t_mode_switch();
        t_bank_edge();
        t_wrap();
        t_bank_edge();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule